// File: doc/BRIEF.md
# Maskable Interrupt Vector Controller

This block sits beside a processor core and decides which pending interrupt request the core services next. It applies three kinds of gating. The trap and software-interrupt requests are never masked. The high-priority external request is gated by an X mask bit that software can clear once but never set again. Every other source is gated both by a global I mask bit and by its own local enable. The highest-ranked eligible request wins, and the block reports it through a one-cycle take pulse and a registered 16-bit vector fetch address.

When table remapping is on, the fixed high-memory vector address is moved into a RAM shadow table by subtracting 0xC180. The core (or the memory system) returns the two-byte entry that was fetched. The block then either tells the core to load its program counter with that entry, or raises an uninitialized-vector error when a remapped entry reads as zero.

The control is a two-state machine. In ST_IDLE the block waits for an eligible request; the transition "accept" (an eligible request is present) moves it to ST_FETCH and launches the vector address. In ST_FETCH it ignores new requests until the entry comes back; the transition "complete" (`vec_rvalid` high) issues a load or an error and returns to ST_IDLE.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `i_mask` and `x_mask` are 1, and `take_int`, `pc_load` and `vec_err` are 0.
- R2: A cycle with `ccr_we`=1 copies `ccr_i_in` into `i_mask`, visible after that clock edge.
- R3: A write can drive `x_mask` from 1 to 0. Once it is 0, no write returns it to 1; only reset does.
- R4: `trap_req` and `swi_req` are taken whatever the values of `i_mask` and `x_mask`. The trap vector is 0xFFF8, the software-interrupt vector is 0xFFF6, and the trap wins when both are pending.
- R5: `xirq_req` is taken only while `x_mask`=0, with vector 0xFFF4. It ranks below trap and software interrupt and above every masked source, whatever the value of `i_mask`.
- R6: Masked source i (bit i of `irq_req`) is eligible only when `i_mask`=0 and bit i of `irq_en` is 1. Its vector is 0xFFF2 − 2·i.
- R7: Among eligible masked sources, the lowest index (the higher vector address) wins.
- R8: A request present in ST_IDLE at a clock edge makes `take_int` high for exactly the next cycle, with `vec_addr` valid in that same cycle. While in ST_FETCH no further take is issued, even if requests stay high.
- R9: With `remap_en`=1 at the accept edge, `vec_addr` is the primary vector minus 0xC180 (for example, 0xFFF0 becomes 0x3E70).
- R10: In ST_FETCH, a cycle with `vec_rvalid`=1 produces a one-cycle `pc_load` with `pc_value`=`vec_rdata` in the next cycle. The exception is a remapped fetch with `vec_rdata`=0x0000, which instead produces a one-cycle `vec_err` and no `pc_load`. Without remapping, a zero entry loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_SRC | Masked source requests, bit 0 highest rank |
| irq_en | input | NUM_SRC | Local enable per masked source |
| xirq_req | input | 1 | High-priority external request |
| swi_req | input | 1 | Software interrupt request |
| trap_req | input | 1 | Unimplemented-instruction trap request |
| ccr_we | input | 1 | Write strobe for the mask bits |
| ccr_i_in | input | 1 | New I mask value |
| ccr_x_in | input | 1 | New X mask value (only 0 has effect) |
| remap_en | input | 1 | Fetch from the RAM shadow table |
| vec_rdata | input | 16 | Fetched vector entry |
| vec_rvalid | input | 1 | Fetched entry valid |
| i_mask | output | 1 | Current I mask bit |
| x_mask | output | 1 | Current X mask bit |
| take_int | output | 1 | One-cycle accept pulse |
| vec_addr | output | 16 | Vector fetch address |
| pc_load | output | 1 | Load program counter pulse |
| pc_value | output | 16 | Value to load |
| vec_err | output | 1 | Uninitialized shadow entry |

## Verification
The bench sweeps every request pattern against every enable pattern for the eight default sources, under both I values. This catches an inverted priority, which would pick the highest index, and a missing enable term, which would take disabled sources. It walks all combinations of the three unmaskable-type requests with X set, then cleared, then with an attempted re-set. That pass exposes an X bit that can be set again, and an external request that leaks through a set X. Remapped fetches for every source check the 0xC180 offset. Zero entries are checked both with and without remapping, to catch an error raised in the wrong mode. A request held through ST_FETCH must not produce a second take pulse.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_FETCH} ivc_state_e;

    localparam int unsigned ADDR_W = 16;
    localparam logic [ADDR_W-1:0] VEC_TRAP      = 16'hFFF8;
    localparam logic [ADDR_W-1:0] VEC_SWI       = 16'hFFF6;
    localparam logic [ADDR_W-1:0] VEC_XIRQ      = 16'hFFF4;
    localparam logic [ADDR_W-1:0] VEC_MASK_TOP  = 16'hFFF2;
    localparam logic [ADDR_W-1:0] TABLE_BASE    = 16'hFF80;
    localparam logic [ADDR_W-1:0] SHADOW_OFFSET = 16'hC180;
    localparam int unsigned MAX_SRC = (VEC_MASK_TOP - TABLE_BASE) / 2 + 1;
endpackage

// File: rtl/ivc_mask_regs.sv
module ivc_mask_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic ccr_we,
    input  logic ccr_i_in,
    input  logic ccr_x_in,
    output logic i_mask,
    output logic x_mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_mask <= 1'b1;
            x_mask <= 1'b1;
        end else if (ccr_we) begin
            i_mask <= ccr_i_in;
            x_mask <= x_mask & ccr_x_in;
        end
    end

    // R3: once cleared, X never returns to 1 while out of reset
    a_r3_x_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        !x_mask |=> !x_mask);
    // R2: I bit holds when not written
    a_r2_i_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ccr_we |=> $stable(i_mask));
endmodule

// File: rtl/ivc_select.sv
module ivc_select
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_req,
    input  logic [NUM_SRC-1:0]  irq_en,
    input  logic                xirq_req,
    input  logic                swi_req,
    input  logic                trap_req,
    input  logic                i_mask,
    input  logic                x_mask,
    output logic                hit,
    output logic [ADDR_W-1:0]   win_addr
);
    logic [NUM_SRC-1:0] eligible;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
        assign eligible[g] = irq_req[g] & irq_en[g] & ~i_mask;
    end

    always_comb begin
        hit      = 1'b1;
        win_addr = VEC_TRAP;
        if (trap_req) begin
            win_addr = VEC_TRAP;
        end else if (swi_req) begin
            win_addr = VEC_SWI;
        end else if (xirq_req && !x_mask) begin
            win_addr = VEC_XIRQ;
        end else begin
            hit = 1'b0;
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
                if (eligible[i]) begin
                    hit      = 1'b1;
                    win_addr = VEC_MASK_TOP - ADDR_W'(2 * i);
                end
            end
        end
    end

    // R4: a trap request always produces the trap vector
    a_r4_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (hit && win_addr == VEC_TRAP));
    // R5: a masked external request alone never wins
    a_r5_xirq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (x_mask && !trap_req && !swi_req) |-> (win_addr != VEC_XIRQ));
    // R6: a set I bit leaves only the unmaskable-type sources
    a_r6_i_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (i_mask && !trap_req && !swi_req && !(xirq_req && !x_mask)) |-> !hit);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_req,
    input  logic [NUM_SRC-1:0]  irq_en,
    input  logic                xirq_req,
    input  logic                swi_req,
    input  logic                trap_req,
    input  logic                ccr_we,
    input  logic                ccr_i_in,
    input  logic                ccr_x_in,
    input  logic                remap_en,
    input  logic [15:0]         vec_rdata,
    input  logic                vec_rvalid,
    output logic                i_mask,
    output logic                x_mask,
    output logic                take_int,
    output logic [15:0]         vec_addr,
    output logic                pc_load,
    output logic [15:0]         pc_value,
    output logic                vec_err
);
    ivc_state_e        state, state_nx;
    logic              hit;
    logic [ADDR_W-1:0] win_addr;
    logic              remap_l;
    logic              accept;
    logic              complete;
    logic              zero_entry;

    initial begin
        if (NUM_SRC < 1 || NUM_SRC > MAX_SRC)
            $error("NUM_SRC out of range for the vector table");
    end

    ivc_mask_regs u_masks (
        .clk      (clk),
        .rst_n    (rst_n),
        .ccr_we   (ccr_we),
        .ccr_i_in (ccr_i_in),
        .ccr_x_in (ccr_x_in),
        .i_mask   (i_mask),
        .x_mask   (x_mask)
    );

    ivc_select #(.NUM_SRC(NUM_SRC)) u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .xirq_req (xirq_req),
        .swi_req  (swi_req),
        .trap_req (trap_req),
        .i_mask   (i_mask),
        .x_mask   (x_mask),
        .hit      (hit),
        .win_addr (win_addr)
    );

    assign accept     = (state == ST_IDLE) && hit;
    assign complete   = (state == ST_FETCH) && vec_rvalid;
    assign zero_entry = remap_l && (vec_rdata == '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept)   state_nx = ST_FETCH;
            ST_FETCH: if (complete) state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_int <= 1'b0;
            vec_addr <= '0;
            remap_l  <= 1'b0;
            pc_load  <= 1'b0;
            pc_value <= '0;
            vec_err  <= 1'b0;
        end else begin
            take_int <= accept;
            pc_load  <= complete && !zero_entry;
            vec_err  <= complete && zero_entry;
            if (accept) begin
                remap_l  <= remap_en;
                vec_addr <= remap_en ? (win_addr - SHADOW_OFFSET) : win_addr;
            end
            if (complete && !zero_entry) pc_value <= vec_rdata;
        end
    end

    // R8: take is a single-cycle pulse issued on entry to ST_FETCH
    a_r8_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> !take_int);
    a_r8_take_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |-> (state == ST_FETCH));
    // R9: primary addresses lie in the table, shadow addresses below it
    a_r9_primary_range: assert property (@(posedge clk) disable iff (!rst_n)
        (take_int && !remap_l) |-> (vec_addr >= TABLE_BASE && !vec_addr[0]));
    a_r9_shadow_range: assert property (@(posedge clk) disable iff (!rst_n)
        (take_int && remap_l) |-> (vec_addr >= TABLE_BASE - SHADOW_OFFSET
                                   && vec_addr < 16'h4000 && !vec_addr[0]));
    // R10: one outcome per fetch, errors only when remapped
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_load && vec_err));
    a_r10_err_remap: assert property (@(posedge clk) disable iff (!rst_n)
        vec_err |-> remap_l);
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] irq_req = '0, irq_en = '0;
    logic xirq_req = 0, swi_req = 0, trap_req = 0;
    logic ccr_we = 0, ccr_i_in = 1, ccr_x_in = 1, remap_en = 0;
    logic [15:0] vec_rdata = '0;
    logic vec_rvalid = 0;
    logic i_mask, x_mask, take_int, pc_load, vec_err;
    logic [15:0] vec_addr, pc_value;

    int nchk = 0;
    int nerr = 0;
    logic m_i = 1'b1, m_x = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl #(.NUM_SRC(N)) u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .xirq_req(xirq_req), .swi_req(swi_req), .trap_req(trap_req),
        .ccr_we(ccr_we), .ccr_i_in(ccr_i_in), .ccr_x_in(ccr_x_in),
        .remap_en(remap_en), .vec_rdata(vec_rdata), .vec_rvalid(vec_rvalid),
        .i_mask(i_mask), .x_mask(x_mask), .take_int(take_int),
        .vec_addr(vec_addr), .pc_load(pc_load), .pc_value(pc_value),
        .vec_err(vec_err)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_ccr(input logic i_v, input logic x_v);
        @(negedge clk);
        ccr_we = 1; ccr_i_in = i_v; ccr_x_in = x_v;
        @(negedge clk);
        ccr_we = 0;
        m_i = i_v;
        m_x = m_x & x_v;
    endtask

    function automatic logic [16:0] model(input logic [N-1:0] rq, input logic [N-1:0] en,
                                          input logic xr, input logic sw, input logic tr);
        if (tr) return {1'b1, 16'hFFF8};
        if (sw) return {1'b1, 16'hFFF6};
        if (xr && !m_x) return {1'b1, 16'hFFF4};
        if (!m_i)
            for (int i = 0; i < N; i++)
                if (rq[i] && en[i]) return {1'b1, 16'(16'hFFF2 - 2 * i)};
        return 17'd0;
    endfunction

    task automatic run_case(input string tag, input logic [N-1:0] rq, input logic [N-1:0] en,
                            input logic xr, input logic sw, input logic tr,
                            input logic rm, input logic [15:0] rd);
        logic [16:0] e;
        logic [15:0] ea;
        e = model(rq, en, xr, sw, tr);
        ea = rm ? e[15:0] - 16'hC180 : e[15:0];
        @(negedge clk);
        irq_req = rq; irq_en = en; xirq_req = xr; swi_req = sw; trap_req = tr; remap_en = rm;
        @(negedge clk);
        chk({tag, " take"}, {15'd0, take_int}, {15'd0, e[16]});
        irq_req = '0; xirq_req = 0; swi_req = 0; trap_req = 0;
        if (e[16]) begin
            chk({tag, " addr"}, vec_addr, ea);
            vec_rvalid = 1; vec_rdata = rd;
            @(negedge clk);
            vec_rvalid = 0;
            if (rm && rd == 16'h0) begin
                chk("R10 err", {15'd0, vec_err}, 16'd1);
                chk("R10 noload", {15'd0, pc_load}, 16'd0);
            end else begin
                chk("R10 load", {15'd0, pc_load}, 16'd1);
                chk("R10 value", pc_value, rd);
                chk("R10 noerr", {15'd0, vec_err}, 16'd0);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 i_mask", {15'd0, i_mask}, 16'd1);
        chk("R1 x_mask", {15'd0, x_mask}, 16'd1);
        chk("R1 take", {15'd0, take_int}, 16'd0);
        chk("R1 load", {15'd0, pc_load}, 16'd0);
        chk("R1 err", {15'd0, vec_err}, 16'd0);
        rst_n = 1;

        // R6 I set blocks every masked source
        for (int r = 0; r < 256; r++)
            run_case("R6 Iset", 8'(r), 8'hFF, 0, 0, 0, 0, 16'h1234);

        wr_ccr(0, 1);
        chk("R2 i_clear", {15'd0, i_mask}, 16'd0);
        // R7 priority over every request pattern
        for (int r = 0; r < 256; r++)
            run_case("R7 prio", 8'(r), 8'hFF, 0, 0, 0, 0, 16'(16'h8000 + r));
        // R6 local enables over every enable pattern
        for (int e = 0; e < 256; e++)
            run_case("R6 en", 8'hFF, 8'(e), 0, 0, 0, 0, 16'(16'h9000 + e));

        // R4 R5 specials with X still set, both I values
        for (int k = 0; k < 16; k++) begin
            wr_ccr(k[3], 1);
            run_case("R4 R5 xset", 8'h05, 8'hFF, k[2], k[1], k[0], 0, 16'hA5A5);
        end
        wr_ccr(1, 0);
        chk("R3 x_clear", {15'd0, x_mask}, 16'd0);
        chk("R2 i_set", {15'd0, i_mask}, 16'd1);
        for (int k = 0; k < 16; k++) begin
            wr_ccr(k[3], 0);
            run_case("R4 R5 xclr", 8'h05, 8'hFF, k[2], k[1], k[0], 0, 16'h5A5A);
        end
        wr_ccr(1, 1);
        chk("R3 x_stays", {15'd0, x_mask}, 16'd0);
        run_case("R3 R5 xirq", 8'h00, 8'h00, 1, 0, 0, 0, 16'h0BEE);

        // R9 remap of every source, R10 nonzero entry loads
        wr_ccr(0, 1);
        for (int i = 0; i < N; i++)
            run_case("R9 remap", 8'(1 << i), 8'hFF, 0, 0, 0, 1, 16'(16'hC000 + i));
        run_case("R9 remap trap", 8'h00, 8'h00, 0, 0, 1, 1, 16'h7777);
        // R10 zero entry: error when remapped, load otherwise
        run_case("R10 zero remap", 8'h02, 8'hFF, 0, 0, 0, 1, 16'h0000);
        run_case("R10 zero plain", 8'h02, 8'hFF, 0, 0, 0, 0, 16'h0000);

        // R8 held request during fetch gives no second take
        @(negedge clk);
        irq_req = 8'h10; irq_en = 8'hFF; remap_en = 0;
        @(negedge clk);
        chk("R8 first take", {15'd0, take_int}, 16'd1);
        chk("R8 addr", vec_addr, 16'hFFEA);
        @(negedge clk);
        chk("R8 no retake", {15'd0, take_int}, 16'd0);
        @(negedge clk);
        chk("R8 still none", {15'd0, take_int}, 16'd0);
        irq_req = '0;
        vec_rvalid = 1; vec_rdata = 16'h2222;
        @(negedge clk);
        vec_rvalid = 0;
        chk("R10 held load", {15'd0, pc_load}, 16'd1);
        @(negedge clk);
        chk("R8 idle after", {15'd0, take_int}, 16'd0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule